// File: doc/BRIEF.md
# Opcode-Addressed I2C Control Register Slave

This block is a receive-only I2C target that holds the configuration of an audio amplifier. It watches the open-drain SCL and SDA lines through synchronizers clocked by a fast system clock, finds START and STOP conditions, and compares the first byte of each transfer with its own address. One bit of that address is chosen by a strap input. After a matching address, every later byte in the same transfer is a complete command. There is no register-pointer byte. The leading bits of each byte pick the target register, and the remaining bits are its new value.

The block holds five control fields and drives them as parallel outputs: a four-bit output-mode code, a headphone control group (input mute, right-headphone shutdown, attenuation step), and three five-bit volume codes for the mono, left and right inputs. A one-cycle strobe marks each register update. After reset the amplifier is silent: all outputs are shut down, mute is on, and every volume is at its lowest code.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: After reset, mode_o is 0, in_mute_o is 1, hp_rsd_o is 1, hp_atten_o is 0, all three volume outputs are 0, sda_pull_o is 0 and wr_stb_o is 0.
- R2: The address byte, sent MSB first and including the write bit 0, is 0xF8 when addr_sel_i is 0 and 0xFA when addr_sel_i is 1. On a match the slave pulls SDA low (sda_pull_o = 1) for the ninth clock.
- R3: A non-matching address gets no acknowledge. Every byte after it is ignored and not acknowledged, and no register changes, until the next START.
- R4: Each data byte after a matched address is acknowledged on the ninth clock. The SDA pull is released after the falling SCL edge that ends that clock.
- R5: A byte of the form 0011_mmmm loads mmmm into mode_o.
- R6: A byte of the form 01_a_bc_d_ee loads a into in_mute_o, d into hp_rsd_o and ee into hp_atten_o (0 = 0 dB, 1 = -12 dB, 2 = -18 dB, 3 = -24 dB). Bits 4:3 (bc) are ignored.
- R7: A byte with top bits 100 loads bits 4:0 into mono_vol_o. Top bits 110 load left_vol_o and top bits 111 load right_vol_o.
- R8: Bytes with top bits 0000, 0001, 0010 or 101 are acknowledged but change no output and give no strobe.
- R9: Any number of command bytes may follow one address. A STOP returns the slave to idle with SDA released, and a repeated START begins a new address phase.
- R10: A register changes only after all eight bits of its byte have arrived, and wr_stb_o is high for exactly one cycle per update. A byte cut short by STOP or START changes nothing.
- R11: The slave behaves the same at 100 kHz and 400 kHz SCL with a 50 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel_i | input | 1 | Address strap, selects address bit 1 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| mode_o | output | 4 | Output-mode code |
| in_mute_o | output | 1 | Input mute |
| hp_rsd_o | output | 1 | Right headphone shutdown |
| hp_atten_o | output | 2 | Headphone attenuation step |
| mono_vol_o | output | 5 | Mono input volume code |
| left_vol_o | output | 5 | Left input volume code |
| right_vol_o | output | 5 | Right input volume code |
| wr_stb_o | output | 1 | One-cycle register-update strobe |

## Verification
The register commit and the start of the acknowledge pull happen on the same system-clock edge, the one that sees the SCL fall after the eighth data bit. The bench sends several command bytes back to back and checks that each one both reads back as an acknowledge on the ninth clock and adds exactly one strobe with the new register value. A STOP or repeated START can also arrive while a byte is only partly shifted in. This is provoked by cutting a byte after four bits, and it is judged by the outputs and strobe count staying unchanged.

// File: rtl/amp_ctl_pkg.sv
`timescale 1ns/1ps
package amp_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 4;
  localparam int VOL_W  = 5;
  localparam int ATT_W  = 2;
  localparam logic [BYTE_W-1:0] ADDR_BASE = 8'hF8;
  localparam int STRAP_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } bus_st_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              mute;
    logic              hp_rsd;
    logic [ATT_W-1:0]  atten;
    logic [VOL_W-1:0]  mono;
    logic [VOL_W-1:0]  left;
    logic [VOL_W-1:0]  right;
  } ctl_regs_t;

  localparam ctl_regs_t REGS_RST = '{mode: '0, mute: 1'b1, hp_rsd: 1'b1,
                                     atten: '0, mono: '0, left: '0, right: '0};
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/i2c_rx_fsm.sv
`timescale 1ns/1ps
module i2c_rx_fsm
  import amp_ctl_pkg::*;
#(
  parameter int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] dev_addr,
  output logic              ack_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_st_e           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shf_q, shf_d;
  logic              ack_q, ack_d;
  logic              start_ev, stop_ev, done;

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    ack_d   = ack_q;
    done    = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && cnt_q != FULL) begin
            shf_d = {shf_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == FULL) begin
            if (state_q == ST_DATA) begin
              ack_d   = 1'b1;
              done    = 1'b1;
              state_d = ST_DATA_ACK;
            end else if (shf_q == dev_addr) begin
              ack_d   = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            cnt_d   = '0;
            state_d = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shf_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shf_q   <= shf_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_o       = ack_q;
  assign byte_done_o = done;
  assign byte_o      = shf_q;

  // R4: the pull may only begin on a falling SCL edge
  p_ack_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(scl_fall));
  // R9: STOP returns to idle with SDA released
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!ack_q && state_q == ST_IDLE));
  // R10: a committed byte is always acknowledged
  p_commit_acks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ack_q);
endmodule

// File: rtl/amp_reg_decode.sv
`timescale 1ns/1ps
module amp_reg_decode
  import amp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output ctl_regs_t         regs_o,
  output logic              wr_stb_o
);
  ctl_regs_t regs_q, regs_d;
  logic      stb_q, hit;

  always_comb begin
    regs_d = regs_q;
    hit    = 1'b0;
    if (byte_done_i) begin
      if (byte_i[7:4] == 4'b0011) begin
        regs_d.mode = byte_i[MODE_W-1:0];
        hit = 1'b1;
      end else if (byte_i[7:6] == 2'b01) begin
        regs_d.mute   = byte_i[5];
        regs_d.hp_rsd = byte_i[2];
        regs_d.atten  = byte_i[ATT_W-1:0];
        hit = 1'b1;
      end else if (byte_i[7:5] == 3'b100) begin
        regs_d.mono = byte_i[VOL_W-1:0];
        hit = 1'b1;
      end else if (byte_i[7:5] == 3'b110) begin
        regs_d.left = byte_i[VOL_W-1:0];
        hit = 1'b1;
      end else if (byte_i[7:5] == 3'b111) begin
        regs_d.right = byte_i[VOL_W-1:0];
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= REGS_RST;
      stb_q  <= 1'b0;
    end else begin
      if (byte_done_i) regs_q <= regs_d;
      stb_q <= hit;
    end
  end

  assign regs_o   = regs_q;
  assign wr_stb_o = stb_q;

  // R10: strobe is a single-cycle pulse
  p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R10: registers move only together with the strobe
  p_regs_with_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_q) |-> stb_q);
endmodule

// File: rtl/amp_ctl_i2c_slave.sv
`timescale 1ns/1ps
module amp_ctl_i2c_slave
  import amp_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              in_mute_o,
  output logic              hp_rsd_o,
  output logic [ATT_W-1:0]  hp_atten_o,
  output logic [VOL_W-1:0]  mono_vol_o,
  output logic [VOL_W-1:0]  left_vol_o,
  output logic [VOL_W-1:0]  right_vol_o,
  output logic              wr_stb_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic byte_done;
  logic [BYTE_W-1:0] rx_byte, dev_addr;
  ctl_regs_t regs;

  always_comb begin
    dev_addr = ADDR_BASE;
    dev_addr[STRAP_BIT] = addr_sel_i;
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  i2c_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .dev_addr(dev_addr), .ack_o(sda_pull_o),
    .byte_done_o(byte_done), .byte_o(rx_byte));

  amp_reg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .byte_done_i(byte_done), .byte_i(rx_byte),
    .regs_o(regs), .wr_stb_o(wr_stb_o));

  assign mode_o      = regs.mode;
  assign in_mute_o   = regs.mute;
  assign hp_rsd_o    = regs.hp_rsd;
  assign hp_atten_o  = regs.atten;
  assign mono_vol_o  = regs.mono;
  assign left_vol_o  = regs.left;
  assign right_vol_o = regs.right;
endmodule

// File: tb/sim_amp_ctl_i2c_slave.sv
`timescale 1ns/1ps
module sim_amp_ctl_i2c_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull, in_mute, hp_rsd, wr_stb;
  logic [3:0] mode;
  logic [1:0] atten;
  logic [4:0] mono, left, right;
  wire sda_line = sda_m & ~sda_pull;

  int errors = 0, checks = 0, stb_cnt = 0, q_cyc = 31;

  always #10 clk = ~clk;

  amp_ctl_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .mode_o(mode),
    .in_mute_o(in_mute), .hp_rsd_o(hp_rsd), .hp_atten_o(atten),
    .mono_vol_o(mono), .left_vol_o(left), .right_vol_o(right),
    .wr_stb_o(wr_stb));

  always @(negedge clk) if (wr_stb) stb_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (q_cyc) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait();
      scl = 1'b1; qwait(); qwait();
      scl = 1'b0; qwait();
    end
  endtask

  // sends a byte, returns acknowledge seen and whether SDA was released after
  task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
    send_bits(b, 8);
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    acked = (sda_line == 1'b0);
    qwait();
    scl = 1'b0; qwait();
    released = (sda_line == 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);       chk("R1 mute", in_mute, 1);
    chk("R1 rsd", hp_rsd, 1);      chk("R1 atten", atten, 0);
    chk("R1 vols", {mono, left, right}, 0);
    chk("R1 pull", sda_pull, 0);   chk("R1 stb", wr_stb, 0);
  endtask

  task automatic t_mode();
    bit a, r; int s0 = stb_cnt;
    bus_start();
    send_byte(8'hF8, a, r); chk("R2 addr ack F8", a, 1);
    send_byte(8'h35, a, r); chk("R4 data ack", a, 1); chk("R4 release", r, 1);
    bus_stop();
    chk("R5 mode", mode, 5);
    chk("R10 one strobe", stb_cnt - s0, 1);
    chk("R9 idle released", sda_pull, 0);
  endtask

  task automatic t_headphone();
    bit a, r;
    bus_start();
    send_byte(8'hF8, a, r);
    send_byte(8'h7B, a, r);
    chk("R6 mute set", in_mute, 1); chk("R6 rsd", hp_rsd, 0);
    chk("R6 atten 3", atten, 3);    chk("R6 bits43 ignored mode", mode, 5);
    send_byte(8'h46, a, r);
    bus_stop();
    chk("R6 mute clr", in_mute, 0); chk("R6 rsd set", hp_rsd, 1);
    chk("R6 atten 2", atten, 2);
  endtask

  task automatic t_volumes();
    bit a, r; int s0 = stb_cnt;
    bus_start();
    send_byte(8'hF8, a, r);
    send_byte(8'h9F, a, r); chk("R7 ack mono", a, 1);
    send_byte(8'hCA, a, r); chk("R9 ack left", a, 1);
    send_byte(8'hE1, a, r); chk("R9 ack right", a, 1);
    bus_stop();
    chk("R7 mono", mono, 31); chk("R7 left", left, 10); chk("R7 right", right, 1);
    chk("R10 three strobes", stb_cnt - s0, 3);
  endtask

  task automatic t_unmatched();
    bit a, r; int s0 = stb_cnt;
    logic [7:0] codes [4] = '{8'h0F, 8'h1F, 8'h2F, 8'hA5};
    bus_start();
    send_byte(8'hF8, a, r);
    foreach (codes[i]) begin
      send_byte(codes[i], a, r);
      chk("R8 acked", a, 1);
    end
    bus_stop();
    chk("R8 no strobe", stb_cnt - s0, 0);
    chk("R8 regs kept", {mode, in_mute, hp_rsd, atten, mono, left, right},
        {4'd5, 1'b0, 1'b1, 2'd2, 5'd31, 5'd10, 5'd1});
  endtask

  task automatic t_mismatch();
    bit a, r; int s0 = stb_cnt;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hFA, a, r); chk("R3 no addr ack", a, 0);
    send_byte(8'h3C, a, r); chk("R3 data ignored no ack", a, 0);
    bus_stop();
    chk("R3 mode kept", mode, 5);
    chk("R3 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_strap();
    bit a, r;
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hF8, a, r); chk("R3 F8 refused strap1", a, 0);
    bus_start();
    send_byte(8'hFA, a, r); chk("R2 addr ack FA", a, 1);
    send_byte(8'h3E, a, r);
    bus_stop();
    chk("R2 mode via strap", mode, 14);
    addr_sel = 1'b0;
  endtask

  task automatic t_partial();
    bit a, r; int s0 = stb_cnt;
    bus_start();
    send_byte(8'hF8, a, r);
    send_bits(8'h37, 4);
    bus_stop();
    chk("R10 cut by stop", mode, 14);
    bus_start();
    send_byte(8'hF8, a, r);
    send_bits(8'hDF, 5);
    bus_start();
    send_byte(8'hF8, a, r); chk("R9 repeated start ack", a, 1);
    send_byte(8'h33, a, r);
    bus_stop();
    chk("R10 cut by start", left, 10);
    chk("R9 after rstart", mode, 3);
    chk("R10 one strobe", stb_cnt - s0, 1);
  endtask

  task automatic t_slow();
    bit a, r;
    q_cyc = 125;
    bus_start();
    send_byte(8'hF8, a, r); chk("R11 ack 100k", a, 1);
    send_byte(8'h3A, a, r); chk("R11 release 100k", r, 1);
    send_byte(8'hD5, a, r);
    bus_stop();
    chk("R11 mode 100k", mode, 10);
    chk("R11 left 100k", left, 21);
    q_cyc = 31;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mode();
    t_headphone();
    t_volumes();
    t_unmatched();
    t_mismatch();
    t_strap();
    t_partial();
    t_slow();
    finish_run();
  end
endmodule